// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial frames on a single line. A byte is written into a one-entry holding register. When transmission is enabled, the byte moves into a shift register. The line then carries a low start bit, the data bits least significant first, an optional parity bit, and one or more high stop bits. When no frame is being sent, the line stays high (mark).

The frame shape is read from an 8-bit mode byte at the moment each frame starts:
- bits [3:2] set the character length;
- bits [5:4] set the parity;
- bits [7:6] set the stop length;
- bits [1:0] set how many transmit-clock ticks make up one bit time.

The transmit clock is given as a one-cycle tick qualifier on the block clock. The bit-time counters advance only on ticks.

A break control forces the line low at once. Two flags report the state of the buffer:
- a ready flag shows that the holding register can accept a byte;
- an empty flag shows that nothing is held and nothing is being shifted.

Top module: `serialTxCore`

## Requirements
- R1: After reset, txd is 1, txRdy is 1 and txEmpty is 1.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the stop bits at 1. With a steady tick, each start, data and parity bit lasts F clock cycles, where F is the baud factor.
- R3: modeWord[3:2] sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R4: modeWord[4]=0 sends no parity bit. modeWord[5:4]=01 appends an even-parity bit and 11 appends an odd-parity bit, placed right after the last data bit. Parity covers only the data bits that are sent.
- R5: modeWord[7:6] sets the stop length: 01 is F ticks, 10 is 3F/2 ticks (24 at x16, 96 at x64, and 2 ticks at x1), 11 is 2F ticks, and 00 is treated as 01.
- R6: modeWord[1:0] sets F: 01 gives 1, 10 gives 16, 11 gives 64, and 00 is treated as 01. The bit-time counter advances only in cycles where txClkTick is 1.
- R7: txRdy is 0 from the clock edge that loads a byte until the clock edge at which that byte moves into the shifter. txRdy is 1 at all other times.
- R8: While txEnable is 0, no frame starts. A loaded byte waits in the holding register, txd stays 1, and the frame starts on the first clock edge at which txEnable is 1.
- R9: While sendBreak is 1, txd is 0 in the same cycle, in every state. The frame in progress keeps its timing.
- R10: txEmpty is 1 only when no frame is in progress and the holding register is empty.
- R11: The mode byte is sampled when a frame starts. Changes to it during the frame do not alter that frame.
- R12: If a byte is waiting and txEnable is 1 when the last stop tick ends, the start bit of the next frame follows in the very next cycle, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWord | input | 8 | Frame format and baud factor |
| txData | input | 8 | Byte to be sent |
| txLoad | input | 1 | Writes txData into the holding register |
| txEnable | input | 1 | Allows new frames to start |
| sendBreak | input | 1 | Forces txd low |
| txClkTick | input | 1 | Transmit clock tick qualifier |
| txd | output | 1 | Serial line |
| txRdy | output | 1 | Holding register empty |
| txEmpty | output | 1 | Holding register empty and shifter idle |

## Verification
A wrong internal state shows up on txd, and it shows up fast:
- A bit counter that is off by one, or a bad length decode, moves every later edge of the frame. The bench compares txd with an independently built waveform on every cycle, so the first wrong cycle is caught.
- A parity bit computed on the wrong bits turns into a single wrong bit time straight after the data.
- A mode byte latched at the wrong moment changes the frame length a few cycles after the mode input changes.
- A lost or duplicated holding flag appears on txRdy or txEmpty within one cycle of a load or a transfer.
- Missing back-to-back chaining appears as an extra mark cycle between two frames.

// File: rtl/txPkg.sv
package txPkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;

  typedef enum logic [1:0] {SEL_MARK, SEL_START, SEL_DATA, SEL_PARITY} lineSel_e;

  typedef struct packed {
    logic     takeHold;
    logic     shift;
    lineSel_e sel;
    logic [3:0] charLen;
    logic     parOdd;
  } dpStrobe_t;

  function automatic logic [6:0] modeBitTicks(input logic [7:0] m);
    case (m[1:0])
      2'b10:   return 7'd16;
      2'b11:   return 7'd64;
      default: return 7'd1;
    endcase
  endfunction

  function automatic logic [7:0] modeStopTicks(input logic [7:0] m);
    logic [7:0] f;
    f = {1'b0, modeBitTicks(m)};
    case (m[7:6])
      2'b10:   return (f == 8'd1) ? 8'd2 : (f + (f >> 1));
      2'b11:   return f << 1;
      default: return f;
    endcase
  endfunction

  function automatic logic [3:0] modeCharLen(input logic [7:0] m);
    return 4'd5 + {2'b00, m[3:2]};
  endfunction
endpackage

// File: rtl/txDatapath.sv
module txDatapath
  import txPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txLoad,
  input  dpStrobe_t         strobe,
  output logic              holdFull,
  output logic              lineBit
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic              parityBit;
  logic              parityNext;

  always_comb begin
    parityNext = strobe.parOdd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(strobe.charLen)) parityNext = parityNext ^ holdReg[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (txLoad) begin
      holdReg  <= txData;
      holdFull <= 1'b1;
    end else if (strobe.takeHold) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else if (strobe.takeHold) begin
      shiftReg  <= holdReg;
      parityBit <= parityNext;
    end else if (strobe.shift) begin
      shiftReg  <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (strobe.sel)
      SEL_START:  lineBit = 1'b0;
      SEL_DATA:   lineBit = shiftReg[0];
      SEL_PARITY: lineBit = parityBit;
      default:    lineBit = 1'b1;
    endcase
  end

  assert_take_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeHold && !txLoad) |=> !holdFull);

  assert_load_fills_R7: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> holdFull);
endmodule

// File: rtl/txCtrl.sv
module txCtrl
  import txPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [7:0] modeWord,
  input  logic      txEnable,
  input  logic      txClkTick,
  input  logic      holdFull,
  output dpStrobe_t strobe,
  output logic      busy
);
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bitIdx;
  logic [6:0]       bitLen;
  logic [7:0]       stopLen;
  logic [3:0]       charLen;
  logic             parEn;
  logic [CNT_W-1:0] lastCnt;
  logic             bitDone;
  logic             canTake;
  logic             takeNow;

  assign canTake = holdFull && txEnable;
  assign lastCnt = (state == ST_STOP) ? (CNT_W'(stopLen) - 1'b1) : (CNT_W'(bitLen) - 1'b1);
  assign bitDone = txClkTick && (cnt == lastCnt) && (state != ST_IDLE);
  assign takeNow = canTake && ((state == ST_IDLE) || (state == ST_STOP && bitDone));
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe.takeHold = takeNow;
    strobe.shift    = (state == ST_DATA) && bitDone;
    strobe.charLen  = modeCharLen(modeWord);
    strobe.parOdd   = modeWord[5];
    case (state)
      ST_START:  strobe.sel = SEL_START;
      ST_DATA:   strobe.sel = SEL_DATA;
      ST_PARITY: strobe.sel = SEL_PARITY;
      default:   strobe.sel = SEL_MARK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      bitLen  <= 7'd1;
      stopLen <= 8'd1;
      charLen <= 4'd5;
      parEn   <= 1'b0;
    end else if (takeNow) begin
      state   <= ST_START;
      cnt     <= '0;
      bitIdx  <= '0;
      bitLen  <= modeBitTicks(modeWord);
      stopLen <= modeStopTicks(modeWord);
      charLen <= modeCharLen(modeWord);
      parEn   <= modeWord[4];
    end else if (state != ST_IDLE && txClkTick) begin
      cnt <= bitDone ? '0 : cnt + 1'b1;
      if (bitDone) begin
        case (state)
          ST_START: begin
            state  <= ST_DATA;
            bitIdx <= '0;
          end
          ST_DATA: begin
            if (bitIdx == charLen - 1'b1) state <= parEn ? ST_PARITY : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end
          ST_PARITY: state <= ST_STOP;
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_take_enabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeHold |-> (txEnable && holdFull));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (cnt <= lastCnt));

  assert_mode_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !takeNow) |=> ($stable(bitLen) && $stable(stopLen) && $stable(charLen) && $stable(parEn)));
endmodule

// File: rtl/serialTxCore.sv
module serialTxCore
  import txPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] modeWord,
  input  logic [7:0] txData,
  input  logic       txLoad,
  input  logic       txEnable,
  input  logic       sendBreak,
  input  logic       txClkTick,
  output logic       txd,
  output logic       txRdy,
  output logic       txEmpty
);
  dpStrobe_t strobe;
  logic      holdFull;
  logic      lineBit;
  logic      busy;

  txCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .txEnable(txEnable),
    .txClkTick(txClkTick), .holdFull(holdFull), .strobe(strobe), .busy(busy)
  );

  txDatapath i_dp (
    .clk(clk), .rstN(rstN), .txData(txData), .txLoad(txLoad),
    .strobe(strobe), .holdFull(holdFull), .lineBit(lineBit)
  );

  assign txd     = lineBit && !sendBreak;
  assign txRdy   = !holdFull;
  assign txEmpty = !holdFull && !busy;

  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txd);

  assert_idle_mark_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !sendBreak) |-> txd);
endmodule

// File: tb/test_serialTxCore.sv
module test_serialTxCore;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] modeWord = 8'h4D;
  logic [7:0] txData = 8'h00;
  logic txLoad = 1'b0;
  logic txEnable = 1'b1;
  logic sendBreak = 1'b0;
  logic txClkTick = 1'b1;
  logic txd, txRdy, txEmpty;

  int checks = 0;
  int errors = 0;
  logic expWave [0:2047];
  int expLen;

  always #(CLK_PERIOD/2) clk = ~clk;

  serialTxCore i_serialTxCore (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .txData(txData), .txLoad(txLoad),
    .txEnable(txEnable), .sendBreak(sendBreak), .txClkTick(txClkTick),
    .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushBits(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      expWave[expLen] = v;
      expLen++;
    end
  endtask

  task automatic addFrame(input logic [7:0] m, input logic [7:0] d);
    int f, n, st;
    logic p;
    f = (m[1:0] == 2'b10) ? 16 : (m[1:0] == 2'b11) ? 64 : 1;
    n = 5 + int'(m[3:2]);
    case (m[7:6])
      2'b10:   st = (f == 1) ? 2 : (f * 3) / 2;
      2'b11:   st = 2 * f;
      default: st = f;
    endcase
    pushBits(1'b0, f);
    p = m[5];
    for (int b = 0; b < n; b++) begin
      pushBits(d[b], f);
      p = p ^ d[b];
    end
    if (m[4]) pushBits(p, f);
    pushBits(1'b1, st);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!txEmpty) @(negedge clk);
  endtask

  task automatic runFrames(input logic [7:0] m, input logic [7:0] d0, input bit two,
                           input logic [7:0] d1, input int changeAt,
                           input logic [7:0] altMode, input string tag);
    int mism, firstBad;
    expLen = 0;
    addFrame(m, d0);
    if (two) addFrame(m, d1);
    @(negedge clk);
    modeWord = m; txData = d0; txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
    check(txRdy == 1'b0, {tag, " R7 txRdy after load"}, txRdy, 0);
    mism = 0; firstBad = -1;
    for (int i = 0; i < expLen; i++) begin
      @(negedge clk);
      if (txd !== expWave[i]) begin
        if (firstBad < 0) firstBad = i;
        mism++;
      end
      if (i == 0) begin
        check(txRdy == 1'b1, {tag, " R7 txRdy after transfer"}, txRdy, 1);
        check(txEmpty == 1'b0, {tag, " R10 txEmpty during frame"}, txEmpty, 0);
      end
      if (two && i == 2) begin txData = d1; txLoad = 1'b1; end
      if (two && i == 3) txLoad = 1'b0;
      if (i == changeAt) modeWord = altMode;
    end
    check(mism == 0, {tag, " waveform mismatches (first bad cycle shown in next field)"}, mism, 0);
    if (mism != 0) $display("  first mismatching cycle %0d", firstBad);
    @(negedge clk);
    check(txd == 1'b1 && txEmpty == 1'b1, {tag, " R10 idle after frame"}, {txd, txEmpty}, 3);
    modeWord = m;
  endtask

  task automatic testReset();
    check(txd == 1'b1, "R1 txd at reset", txd, 1);
    check(txRdy == 1'b1, "R1 txRdy at reset", txRdy, 1);
    check(txEmpty == 1'b1, "R1 txEmpty at reset", txEmpty, 1);
  endtask

  task automatic testTickGate();
    int bad;
    @(negedge clk);
    modeWord = 8'h4D; txData = 8'h01; txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0; txClkTick = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (txd !== 1'b0) bad++;
    end
    check(bad == 0, "R6 start bit held without ticks", bad, 0);
    txClkTick = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R6 data bit after tick resumes", txd, 1);
    waitIdle();
  endtask

  task automatic testEnable();
    int bad;
    @(negedge clk);
    txEnable = 1'b0; modeWord = 8'h4D; txData = 8'h55; txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || txRdy !== 1'b0 || txEmpty !== 1'b0) bad++;
    end
    check(bad == 0, "R8 byte waits while disabled", bad, 0);
    txEnable = 1'b1;
    @(negedge clk);
    check(txd == 1'b0 && txRdy == 1'b1, "R8 start after enable", {txd, txRdy}, 1);
    waitIdle();
  endtask

  task automatic testBreak();
    @(negedge clk);
    sendBreak = 1'b1;
    #1 check(txd == 1'b0, "R9 break while idle", txd, 0);
    sendBreak = 1'b0;
    #1 check(txd == 1'b1, "R9 line returns to mark", txd, 1);
    modeWord = 8'h4D; txData = 8'hFF; txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(txd == 1'b1, "R9 data bit high before break", txd, 1);
    sendBreak = 1'b1;
    #1 check(txd == 1'b0, "R9 break during frame", txd, 0);
    @(negedge clk);
    sendBreak = 1'b0;
    waitIdle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/4);
    testReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testReset();
    runFrames(8'h4D, 8'hA5, 0, 8'h00, -1, 8'h00, "R2 8N1 x1");
    runFrames(8'h41, 8'hFF, 0, 8'h00, -1, 8'h00, "R3 5 bit");
    runFrames(8'h45, 8'h2A, 0, 8'h00, -1, 8'h00, "R3 6 bit");
    runFrames(8'h5D, 8'h07, 0, 8'h00, -1, 8'h00, "R4 even");
    runFrames(8'h7D, 8'h07, 0, 8'h00, -1, 8'h00, "R4 odd");
    runFrames(8'h59, 8'h81, 0, 8'h00, -1, 8'h00, "R4 7 bit even");
    runFrames(8'h8E, 8'h3C, 0, 8'h00, -1, 8'h00, "R5 1.5 stop x16");
    runFrames(8'h8D, 8'h3C, 0, 8'h00, -1, 8'h00, "R5 1.5 stop x1");
    runFrames(8'hCD, 8'h96, 0, 8'h00, -1, 8'h00, "R5 2 stop");
    runFrames(8'h0D, 8'h96, 0, 8'h00, -1, 8'h00, "R5 invalid stop");
    runFrames(8'h7F, 8'h3C, 0, 8'h00, -1, 8'h00, "R6 x64 odd");
    runFrames(8'hCA, 8'h4B, 0, 8'h00, -1, 8'h00, "R6 x16 7 bit 2 stop");
    runFrames(8'h4C, 8'h5A, 0, 8'h00, -1, 8'h00, "R6 factor 00");
    testTickGate();
    testEnable();
    testBreak();
    runFrames(8'h4D, 8'hC3, 0, 8'h00, 3, 8'hFF, "R11 mode change");
    runFrames(8'h5D, 8'h12, 1, 8'hE7, -1, 8'h00, "R12 back to back");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule